// File: doc/BRIEF.md
# DDR4 Command-Pair Gap Monitor

This block watches an already decoded DDR4 command stream without ever driving it. In each clock cycle it may see one command, given as a type, a rank, a bank group and a bank. For fourteen fixed ordered command pairs it measures how many clock edges separate the second command from the most recent matching first command. It keeps the smallest gap seen for each pair. Each pair is qualified by same or different rank, same or different bank group, or same bank, depending on the pair.

Each pair also has a limit input that holds the timing value the memory specification requires. When a measured gap falls below that limit, a sticky flag for the pair is set. The block also counts column commands that go to the same bank group as the previous column command, and column commands that go to a different one. Together these counts show how well the controller spreads its accesses across bank groups.

The per-pair results are exposed as flat vectors, with pair `i` at bits `[i*GW +: GW]`. A surrounding debug or performance unit can sample them at any time.

Top module: `ddr_cmd_gap_monitor`

## Requirements
- R1: After reset every minimum field reads all ones (255 with GW=8), every flag is clear and both bank-group counters are zero.
- R2: Commands are coded on `cmd_type` as 0 idle/deselect, 1 activate, 2 read, 3 write, 4 single-bank precharge, 5 precharge-all, 6 refresh and 7 other. Suppose a second command is sampled N clock edges after the first, where N is below the all-ones value. The block then measures N for the pair. A minimum field takes a measured gap only if the gap is strictly smaller than the stored value.
- R3: These pairs are all on the same rank. Pair 0 is read to write, any bank group. Pair 1 is read to precharge, and pair 2 is write to precharge. For pairs 1 and 2, a single-bank precharge pairs only with a read or write to the identical bank group and bank. A precharge-all pairs with the latest read or write anywhere on the rank.
- R4: These pairs need the two commands on different ranks. Pair 3 is read to read, pair 4 is read to write, pair 5 is write to read and pair 6 is write to write.
- R5: These pairs are on the same rank and are split by bank group. Pair 7 is read to read in the same bank group and pair 8 is read to read in a different bank group. Pair 9 is write to write in the same bank group and pair 10 is write to write in a different bank group.
- R6: These pairs are on the same rank. Pair 11 is write to read in the same bank group and pair 12 is write to read in a different bank group. Pair 13 is activate to activate in the same bank group.
- R7: A cycle with `cmd_vld` low, or with type 0, changes no minimum, no flag and no counter, whatever the other inputs hold. Gaps keep counting across such cycles.
- R8: Bit i of `viol` becomes 1 when pair i measures a gap strictly below `lim_flat[i*GW +: GW]`. The bit then stays at 1 until reset. A gap equal to the limit does not set it.
- R9: Gap measurement saturates at all ones and never wraps. A gap of all ones or more never changes a minimum.
- R10: The block looks only at bank groups, ignoring rank, when it compares a read or write with the previous read or write. A match increments `bg_same_cnt` and a mismatch increments `bg_diff_cnt`, both saturating. The first column command after reset increments neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_type | input | 3 | Command code (see R2) |
| cmd_rank | input | RANK_W | Target rank |
| cmd_bg | input | BG_W | Target bank group |
| cmd_bank | input | BANK_W | Target bank within the group |
| lim_flat | input | 14*GW | Per-pair spec limit, pair i at [i*GW +: GW] |
| min_flat | output | 14*GW | Per-pair smallest measured gap |
| viol | output | 14 | Sticky per-pair limit violation |
| bg_same_cnt | output | CW | Column commands to the same bank group as the previous one |
| bg_diff_cnt | output | CW | Column commands to a different bank group |

## Verification
The bench aims at the qualifiers. It checks that a single-bank precharge ignores a read to another bank, that a precharge-all picks up the latest read on the whole rank, and that a read on another rank lands in the different-rank pair and not in a same-rank one. A design that mixed up those keys would post small, wrong minima in neighbouring pairs. The bench spaces two commands 300 cycles apart, which catches a wrapping counter: such a counter would post a bogus 44. It also drives idle cycles that carry a write code with the strobe low, which exposes a monitor that treats deselects as real commands. The bench places a gap exactly equal to a limit, which separates strict from inclusive comparison. It also checks that a later, larger gap never raises a minimum or clears a flag.

// File: rtl/cmdgap_pkg.sv
`timescale 1ns/1ps
package cmdgap_pkg;
    typedef enum logic [2:0] {
        CMD_DES  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6,
        CMD_MISC = 3'd7
    } cmd_e;

    // history kinds kept per bank
    localparam int NKIND  = 3;
    localparam int K_ACT  = 0;
    localparam int K_RD   = 1;
    localparam int K_WR   = 2;

    // ordered pair slots
    localparam int NPAIR          = 14;
    localparam int P_RD_WR_SR     = 0;
    localparam int P_RD_PRE_SR    = 1;
    localparam int P_WR_PRE_SR    = 2;
    localparam int P_RD_RD_DR     = 3;
    localparam int P_RD_WR_DR     = 4;
    localparam int P_WR_RD_DR     = 5;
    localparam int P_WR_WR_DR     = 6;
    localparam int P_RD_RD_SG     = 7;
    localparam int P_RD_RD_DG     = 8;
    localparam int P_WR_WR_SG     = 9;
    localparam int P_WR_WR_DG     = 10;
    localparam int P_WR_RD_SG     = 11;
    localparam int P_WR_RD_DG     = 12;
    localparam int P_ACT_ACT_SG   = 13;
endpackage

// File: rtl/cmdgap_age_track.sv
`timescale 1ns/1ps
// Per-bank saturating "clocks since last ACT/RD/WR" history.
// All ones means "never seen or too long ago".
module cmdgap_age_track import cmdgap_pkg::*; #(
    parameter int RANK_W = 1,
    parameter int BG_W   = 2,
    parameter int BANK_W = 2,
    parameter int GW     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_vld,
    input  logic [1:0]          hit_kind,
    input  logic [RANK_W-1:0]   hit_rank,
    input  logic [BG_W-1:0]     hit_bg,
    input  logic [BANK_W-1:0]   hit_bank,
    output logic [NKIND-1:0][(1<<RANK_W)-1:0][(1<<BG_W)-1:0][(1<<BANK_W)-1:0][GW-1:0] age_o
);
    localparam int NRANK = 1 << RANK_W;
    localparam int NBG   = 1 << BG_W;
    localparam int NBANK = 1 << BANK_W;

    typedef struct packed {
        logic [NKIND-1:0][NRANK-1:0][NBG-1:0][NBANK-1:0][GW-1:0] age;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < NKIND; k++) begin
            for (int r = 0; r < NRANK; r++) begin
                for (int g = 0; g < NBG; g++) begin
                    for (int b = 0; b < NBANK; b++) begin
                        if (s_q.age[k][r][g][b] != {GW{1'b1}}) begin
                            s_d.age[k][r][g][b] = s_q.age[k][r][g][b] + GW'(1);
                        end
                    end
                end
            end
        end
        if (hit_vld) begin
            s_d.age[hit_kind][hit_rank][hit_bg][hit_bank] = GW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign age_o = s_q.age;
endmodule

// File: rtl/cmdgap_gap_select.sv
`timescale 1ns/1ps
// Combinational: reduce the per-bank history to one candidate gap per pair.
module cmdgap_gap_select import cmdgap_pkg::*; #(
    parameter int RANK_W = 1,
    parameter int BG_W   = 2,
    parameter int BANK_W = 2,
    parameter int GW     = 8
) (
    input  logic [NKIND-1:0][(1<<RANK_W)-1:0][(1<<BG_W)-1:0][(1<<BANK_W)-1:0][GW-1:0] age_i,
    input  logic                cmd_vld,
    input  logic [2:0]          cmd_type,
    input  logic [RANK_W-1:0]   cmd_rank,
    input  logic [BG_W-1:0]     cmd_bg,
    input  logic [BANK_W-1:0]   cmd_bank,
    output logic [NPAIR-1:0][GW-1:0] gap_o,
    output logic [NPAIR-1:0]    gap_vld_o
);
    localparam int NRANK = 1 << RANK_W;
    localparam int NBG   = 1 << BG_W;
    localparam int NBANK = 1 << BANK_W;

    logic [NKIND-1:0][GW-1:0] sb, sbg, dbg, sr, dr;
    logic is_act, is_rd, is_wr, is_pre, is_prea;

    assign is_act  = cmd_vld && (cmd_type == CMD_ACT);
    assign is_rd   = cmd_vld && (cmd_type == CMD_RD);
    assign is_wr   = cmd_vld && (cmd_type == CMD_WR);
    assign is_pre  = cmd_vld && (cmd_type == CMD_PRE);
    assign is_prea = cmd_vld && (cmd_type == CMD_PREA);

    // most recent = smallest age within each scope
    always_comb begin
        for (int k = 0; k < NKIND; k++) begin
            sb[k]  = age_i[k][cmd_rank][cmd_bg][cmd_bank];
            sbg[k] = '1;
            dbg[k] = '1;
            sr[k]  = '1;
            dr[k]  = '1;
            for (int r = 0; r < NRANK; r++) begin
                for (int g = 0; g < NBG; g++) begin
                    for (int b = 0; b < NBANK; b++) begin
                        if (RANK_W'(r) == cmd_rank) begin
                            if (age_i[k][r][g][b] < sr[k]) sr[k] = age_i[k][r][g][b];
                            if (BG_W'(g) == cmd_bg) begin
                                if (age_i[k][r][g][b] < sbg[k]) sbg[k] = age_i[k][r][g][b];
                            end else begin
                                if (age_i[k][r][g][b] < dbg[k]) dbg[k] = age_i[k][r][g][b];
                            end
                        end else begin
                            if (age_i[k][r][g][b] < dr[k]) dr[k] = age_i[k][r][g][b];
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        gap_o[P_RD_WR_SR]   = sr[K_RD];            gap_vld_o[P_RD_WR_SR]   = is_wr;
        gap_o[P_RD_PRE_SR]  = is_pre ? sb[K_RD] : sr[K_RD];
        gap_vld_o[P_RD_PRE_SR] = is_pre || is_prea;
        gap_o[P_WR_PRE_SR]  = is_pre ? sb[K_WR] : sr[K_WR];
        gap_vld_o[P_WR_PRE_SR] = is_pre || is_prea;
        gap_o[P_RD_RD_DR]   = dr[K_RD];            gap_vld_o[P_RD_RD_DR]   = is_rd;
        gap_o[P_RD_WR_DR]   = dr[K_RD];            gap_vld_o[P_RD_WR_DR]   = is_wr;
        gap_o[P_WR_RD_DR]   = dr[K_WR];            gap_vld_o[P_WR_RD_DR]   = is_rd;
        gap_o[P_WR_WR_DR]   = dr[K_WR];            gap_vld_o[P_WR_WR_DR]   = is_wr;
        gap_o[P_RD_RD_SG]   = sbg[K_RD];           gap_vld_o[P_RD_RD_SG]   = is_rd;
        gap_o[P_RD_RD_DG]   = dbg[K_RD];           gap_vld_o[P_RD_RD_DG]   = is_rd;
        gap_o[P_WR_WR_SG]   = sbg[K_WR];           gap_vld_o[P_WR_WR_SG]   = is_wr;
        gap_o[P_WR_WR_DG]   = dbg[K_WR];           gap_vld_o[P_WR_WR_DG]   = is_wr;
        gap_o[P_WR_RD_SG]   = sbg[K_WR];           gap_vld_o[P_WR_RD_SG]   = is_rd;
        gap_o[P_WR_RD_DG]   = dbg[K_WR];           gap_vld_o[P_WR_RD_DG]   = is_rd;
        gap_o[P_ACT_ACT_SG] = sbg[K_ACT];          gap_vld_o[P_ACT_ACT_SG] = is_act;
    end
endmodule

// File: rtl/cmdgap_pair_stats.sv
`timescale 1ns/1ps
// Per-pair running minimum and sticky limit flag.
module cmdgap_pair_stats import cmdgap_pkg::*; #(
    parameter int GW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPAIR-1:0][GW-1:0] gap_i,
    input  logic [NPAIR-1:0]         gap_vld_i,
    input  logic [NPAIR-1:0][GW-1:0] lim_i,
    output logic [NPAIR-1:0][GW-1:0] min_o,
    output logic [NPAIR-1:0]         viol_o
);
    typedef struct packed {
        logic [NPAIR-1:0][GW-1:0] mn;
        logic [NPAIR-1:0]         flag;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NPAIR; i++) begin
            if (gap_vld_i[i] && (gap_i[i] < s_q.mn[i])) s_d.mn[i]   = gap_i[i];
            if (gap_vld_i[i] && (gap_i[i] < lim_i[i]))  s_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mn: '1, flag: '0};
        else        s_q <= s_d;
    end

    assign min_o  = s_q.mn;
    assign viol_o = s_q.flag;
endmodule

// File: rtl/cmdgap_bg_count.sv
`timescale 1ns/1ps
// Same / different bank group tally for consecutive column commands.
module cmdgap_bg_count #(
    parameter int BG_W = 2,
    parameter int CW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            col_vld,
    input  logic [BG_W-1:0] col_bg,
    output logic [CW-1:0]   same_o,
    output logic [CW-1:0]   diff_o
);
    typedef struct packed {
        logic [BG_W-1:0] prev_bg;
        logic            prev_vld;
        logic [CW-1:0]   same;
        logic [CW-1:0]   diff;
    } bgc_t;

    bgc_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (col_vld) begin
            if (s_q.prev_vld) begin
                if (col_bg == s_q.prev_bg) begin
                    if (s_q.same != {CW{1'b1}}) s_d.same = s_q.same + CW'(1);
                end else begin
                    if (s_q.diff != {CW{1'b1}}) s_d.diff = s_q.diff + CW'(1);
                end
            end
            s_d.prev_bg  = col_bg;
            s_d.prev_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign same_o = s_q.same;
    assign diff_o = s_q.diff;
endmodule

// File: rtl/ddr_cmd_gap_monitor.sv
`timescale 1ns/1ps
module ddr_cmd_gap_monitor import cmdgap_pkg::*; #(
    parameter int RANK_W = 1,
    parameter int BG_W   = 2,
    parameter int BANK_W = 2,
    parameter int GW     = 8,
    parameter int CW     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_vld,
    input  logic [2:0]            cmd_type,
    input  logic [RANK_W-1:0]     cmd_rank,
    input  logic [BG_W-1:0]       cmd_bg,
    input  logic [BANK_W-1:0]     cmd_bank,
    input  logic [NPAIR*GW-1:0]   lim_flat,
    output logic [NPAIR*GW-1:0]   min_flat,
    output logic [NPAIR-1:0]      viol,
    output logic [CW-1:0]         bg_same_cnt,
    output logic [CW-1:0]         bg_diff_cnt
);
    localparam int NRANK = 1 << RANK_W;
    localparam int NBG   = 1 << BG_W;
    localparam int NBANK = 1 << BANK_W;

    logic [NKIND-1:0][NRANK-1:0][NBG-1:0][NBANK-1:0][GW-1:0] age;
    logic [NPAIR-1:0][GW-1:0] gap, lim_p, min_p;
    logic [NPAIR-1:0]         gap_vld;
    logic                     hit_vld, col_vld;
    logic [1:0]               hit_kind;

    always_comb begin
        hit_vld  = 1'b0;
        hit_kind = 2'(K_ACT);
        if (cmd_vld) begin
            case (cmd_type)
                CMD_ACT: begin hit_vld = 1'b1; hit_kind = 2'(K_ACT); end
                CMD_RD:  begin hit_vld = 1'b1; hit_kind = 2'(K_RD);  end
                CMD_WR:  begin hit_vld = 1'b1; hit_kind = 2'(K_WR);  end
                default: ;
            endcase
        end
    end

    assign col_vld  = cmd_vld && ((cmd_type == CMD_RD) || (cmd_type == CMD_WR));
    assign lim_p    = lim_flat;
    assign min_flat = min_p;

    cmdgap_age_track #(.RANK_W(RANK_W), .BG_W(BG_W), .BANK_W(BANK_W), .GW(GW)) u_age (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_kind(hit_kind),
        .hit_rank(cmd_rank), .hit_bg(cmd_bg), .hit_bank(cmd_bank), .age_o(age)
    );

    cmdgap_gap_select #(.RANK_W(RANK_W), .BG_W(BG_W), .BANK_W(BANK_W), .GW(GW)) u_sel (
        .age_i(age), .cmd_vld(cmd_vld), .cmd_type(cmd_type), .cmd_rank(cmd_rank),
        .cmd_bg(cmd_bg), .cmd_bank(cmd_bank), .gap_o(gap), .gap_vld_o(gap_vld)
    );

    cmdgap_pair_stats #(.GW(GW)) u_stats (
        .clk(clk), .rst_n(rst_n), .gap_i(gap), .gap_vld_i(gap_vld),
        .lim_i(lim_p), .min_o(min_p), .viol_o(viol)
    );

    cmdgap_bg_count #(.BG_W(BG_W), .CW(CW)) u_bgc (
        .clk(clk), .rst_n(rst_n), .col_vld(col_vld), .col_bg(cmd_bg),
        .same_o(bg_same_cnt), .diff_o(bg_diff_cnt)
    );
endmodule

// File: rtl/ddr_cmd_gap_monitor_chk.sv
`timescale 1ns/1ps
module ddr_cmd_gap_monitor_chk import cmdgap_pkg::*; #(
    parameter int GW = 8,
    parameter int CW = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_vld,
    input logic [2:0]          cmd_type,
    input logic [NPAIR*GW-1:0] min_flat,
    input logic [NPAIR-1:0]    viol,
    input logic [CW-1:0]       bg_same_cnt,
    input logic [CW-1:0]       bg_diff_cnt
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (min_flat == '1) && (viol == '0) &&
                         (bg_same_cnt == '0) && (bg_diff_cnt == '0));

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_vld || (cmd_type == CMD_DES)) |=>
            $stable(min_flat) && $stable(viol) && $stable(bg_same_cnt) && $stable(bg_diff_cnt));

    a_r10_one_tally: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(bg_same_cnt) && !$stable(bg_diff_cnt)));

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        a_r2_min_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
            min_flat[i*GW +: GW] <= $past(min_flat[i*GW +: GW]));
        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $past(viol[i]) |-> viol[i]);
    end
endmodule

bind ddr_cmd_gap_monitor ddr_cmd_gap_monitor_chk #(.GW(GW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_type(cmd_type),
    .min_flat(min_flat), .viol(viol), .bg_same_cnt(bg_same_cnt), .bg_diff_cnt(bg_diff_cnt)
);

// File: tb/ddr_cmd_gap_monitor_test.sv
`timescale 1ns/1ps
module ddr_cmd_gap_monitor_test;
    localparam int GW = 8;
    localparam int CW = 16;
    localparam int NP = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_vld = 1'b0;
    logic [2:0]      cmd_type = 3'd0;
    logic [0:0]      cmd_rank = '0;
    logic [1:0]      cmd_bg = '0;
    logic [1:0]      cmd_bank = '0;
    logic [NP*GW-1:0] lim_flat = '0;
    logic [NP*GW-1:0] min_flat;
    logic [NP-1:0]   viol;
    logic [CW-1:0]   bg_same_cnt, bg_diff_cnt;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ddr_cmd_gap_monitor uut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_type(cmd_type),
        .cmd_rank(cmd_rank), .cmd_bg(cmd_bg), .cmd_bank(cmd_bank),
        .lim_flat(lim_flat), .min_flat(min_flat), .viol(viol),
        .bg_same_cnt(bg_same_cnt), .bg_diff_cnt(bg_diff_cnt)
    );

    localparam logic [2:0] ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, PREA = 3'd5;

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int mn(input int i);
        return int'(min_flat[i*GW +: GW]);
    endfunction

    task automatic do_reset();
        cmd_vld = 1'b0; cmd_type = 3'd0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one command occupies one edge; inputs return to idle afterwards
    task automatic issue(input logic [2:0] t, input int r, input int g, input int b);
        cmd_vld = 1'b1; cmd_type = t;
        cmd_rank = 1'(r); cmd_bg = 2'(g); cmd_bank = 2'(b);
        @(negedge clk);
        cmd_vld = 1'b0; cmd_type = 3'd0;
    endtask

    // issue so that the command lands n edges after the previous one
    task automatic after(input int n, input logic [2:0] t, input int r, input int g, input int b);
        repeat (n - 1) @(negedge clk);
        issue(t, r, g, b);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 min pair0 reset", mn(0), 255);
        chk("R1 min pair13 reset", mn(13), 255);
        chk("R1 viol reset", int'(viol), 0);
        chk("R1 same count reset", int'(bg_same_cnt), 0);
        chk("R1 diff count reset", int'(bg_diff_cnt), 0);
    endtask

    task automatic t_same_rank();
        do_reset();
        issue(RD, 0, 0, 0);
        after(6, WR, 0, 1, 0);
        chk("R3 pair0 rd->wr", mn(0), 6);
        after(3, PRE, 0, 1, 0);
        chk("R3 pair2 wr->pre same bank", mn(2), 3);
        chk("R3 pair1 pre other bank ignored", mn(1), 255);
        after(2, PREA, 0, 0, 0);
        chk("R3 pair1 rd->prea rank wide", mn(1), 11);
        chk("R2 pair2 larger gap kept", mn(2), 3);
        after(2, RD, 0, 3, 1);
        after(2, PRE, 0, 3, 1);
        chk("R3 pair1 rd->pre same bank", mn(1), 2);
        chk("R4 pair4 untouched", mn(4), 255);
        chk("R8 no flag with zero limits", int'(viol), 0);
    endtask

    task automatic t_diff_rank();
        do_reset();
        issue(RD, 0, 0, 0);
        after(4, RD, 1, 0, 0);
        chk("R4 pair3 rd->rd", mn(3), 4);
        chk("R5 pair7 other rank ignored", mn(7), 255);
        after(5, WR, 0, 2, 0);
        chk("R4 pair4 rd->wr", mn(4), 5);
        chk("R3 pair0 same rank rd->wr", mn(0), 9);
        after(7, RD, 1, 3, 0);
        chk("R4 pair5 wr->rd", mn(5), 7);
        chk("R2 pair3 keeps smaller", mn(3), 4);
        chk("R5 pair8 rd->rd diff bg", mn(8), 12);
        after(3, WR, 0, 1, 0);
        chk("R4 pair6 no prior write other rank", mn(6), 255);
        chk("R5 pair10 wr->wr diff bg", mn(10), 10);
        chk("R4 pair4 lowered", mn(4), 3);
        chk("R10 same count ranks mixed", int'(bg_same_cnt), 1);
        chk("R10 diff count ranks mixed", int'(bg_diff_cnt), 3);
    endtask

    task automatic t_bank_group();
        do_reset();
        issue(RD, 0, 1, 0);
        after(6, RD, 0, 1, 2);
        chk("R5 pair7 rd->rd same bg", mn(7), 6);
        after(4, RD, 0, 2, 0);
        chk("R5 pair8 rd->rd diff bg", mn(8), 4);
        after(5, WR, 0, 2, 0);
        after(5, WR, 0, 2, 1);
        chk("R5 pair9 wr->wr same bg", mn(9), 5);
        after(4, WR, 0, 3, 0);
        chk("R5 pair10 wr->wr diff bg", mn(10), 4);
        after(9, RD, 0, 3, 0);
        chk("R6 pair11 wr->rd same bg", mn(11), 9);
        chk("R6 pair12 wr->rd diff bg", mn(12), 13);
        after(2, RD, 0, 0, 0);
        chk("R6 pair12 lowered", mn(12), 11);
        chk("R5 pair8 lowered", mn(8), 2);
        after(1, ACT, 0, 1, 0);
        after(8, ACT, 0, 1, 3);
        chk("R6 pair13 act->act same bg", mn(13), 8);
        after(2, ACT, 0, 2, 0);
        chk("R6 pair13 other bg ignored", mn(13), 8);
        chk("R10 same count", int'(bg_same_cnt), 4);
        chk("R10 diff count", int'(bg_diff_cnt), 3);
    endtask

    task automatic t_idle();
        do_reset();
        issue(RD, 0, 0, 0);
        cmd_vld = 1'b0; cmd_type = WR; cmd_rank = '0; cmd_bg = '0; cmd_bank = '0;
        repeat (3) @(negedge clk);
        cmd_vld = 1'b1; cmd_type = 3'd0;
        repeat (3) @(negedge clk);
        cmd_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 strobe-low write ignored", mn(0), 255);
        chk("R7 no column tally", int'(bg_same_cnt) + int'(bg_diff_cnt), 0);
        issue(WR, 0, 0, 0);
        chk("R7 gap counts through idle", mn(0), 10);
        chk("R10 first compare same bg", int'(bg_same_cnt), 1);
    endtask

    task automatic t_saturate();
        do_reset();
        issue(RD, 0, 0, 0);
        after(300, WR, 0, 0, 0);
        chk("R9 long gap no wrap", mn(0), 255);
        issue(RD, 0, 0, 0);
        after(254, WR, 0, 0, 0);
        chk("R9 gap just below max", mn(0), 254);
    endtask

    task automatic t_violation();
        do_reset();
        lim_flat = '0;
        lim_flat[9*GW +: GW] = 8'd5;
        lim_flat[7*GW +: GW] = 8'd5;
        issue(WR, 0, 0, 0);
        after(5, WR, 0, 0, 0);
        chk("R8 gap equal limit no flag", int'(viol), 0);
        after(4, WR, 0, 0, 0);
        chk("R8 flag pair9 set", int'(viol), 32'h200);
        after(50, WR, 0, 0, 0);
        chk("R8 flag sticky", int'(viol), 32'h200);
        chk("R2 pair9 min", mn(9), 4);
        lim_flat = '0;
        do_reset();
        chk("R1 reset clears flag", int'(viol), 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_same_rank();
        t_diff_rank();
        t_bank_group();
        t_idle();
        t_saturate();
        t_violation();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule